// File: doc/BRIEF.md
# Hardware Cursor Overlay

This unit lays a cursor over a stream of display pixels. Each incoming beat carries the beam position (x, y) and a 24-bit video colour. The unit returns the same beat one stage later. The returned colour is either the video colour unchanged or one of three programmable cursor colours.

The cursor is a fixed 32 pixels wide. Its height comes from a programmable line count whose only limit is the counter width. Each cursor pixel is a 2-bit code. The codes come from a 64-bit line buffer, which the host or a separate fetch engine writes once per scanline. Fetching the cursor data from memory is outside this block.

The pixel input and the colour output are valid/ready streams. A beat moves when valid and ready are both high in the same cycle. The output holds its beat steady until the consumer accepts it. The input is ready whenever the output stage is empty or is being drained in that same cycle. Position, height, colour and line-buffer controls are plain pins.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1. The latched position and height are all zero, so a height of 0 means no cursor appears until a frame start loads new values.
- R2: A cursor code of 2'b00 is transparent. The video colour passes through unchanged.
- R3: Inside the cursor window, code 2'b01 outputs col1, code 2'b10 outputs col2 and code 2'b11 outputs col3, each replacing the video colour.
- R4: The cursor pixel at x = X+i (i from 0 to 31) takes its code from bits [2i+1:2i] of the line buffer. Pixel 0 is in the two least significant bits.
- R5: The horizontal window is exactly X to X+31. At x = X-1 and at x = X+32 the video colour passes.
- R6: The vertical window is Y to Y+H-1. Rows Y-1 and Y+H show video, and H = 0 shows no cursor at all.
- R7: Changes on cur_x, cur_y and cur_h take effect only when a beat with x = 0 and y = 0 is accepted. That beat and all later beats use the new values. Beats before it keep using the old values.
- R8: A beat accepted at one clock edge appears on the output after that edge. While out_valid is high and out_ready is low, out_valid and out_rgb do not change.
- R9: in_ready is low exactly when out_valid is high and out_ready is low.
- R10: A line_wr pulse loads line_data into the line buffer. Beats accepted after that edge use the new line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Unit can take a beat |
| in_x | input | 12 | Beam column |
| in_y | input | 12 | Beam row |
| in_rgb | input | 24 | Video colour |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the beat |
| out_rgb | output | 24 | Final colour |
| cur_x | input | 12 | Cursor left column |
| cur_y | input | 12 | Cursor top row |
| cur_h | input | 12 | Cursor height in rows |
| col1 | input | 24 | Colour for code 01 |
| col2 | input | 24 | Colour for code 10 |
| col3 | input | 24 | Colour for code 11 |
| line_wr | input | 1 | Load the line buffer |
| line_data | input | 64 | Cursor line, 2 bits per pixel |

## Verification
The embedded properties check the following on every cycle:
- the output is held during a stall;
- every accepted beat produces an output beat;
- the video colour passes whenever the window logic reports no cursor;
- the correct colour register appears for each non-zero code;
- the latched geometry changes only at a frame start.

Some behaviour only the bench scenarios can show:
- the exact window edges in both axes;
- the bit order within the line;
- the zero-height case;
- a register change that is deferred until the next frame start.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int RGB_W = 24;
  typedef logic [RGB_W-1:0] rgb_t;

  typedef enum logic [1:0] {
    CODE_CLEAR = 2'b00,
    CODE_C1    = 2'b01,
    CODE_C2    = 2'b10,
    CODE_C3    = 2'b11
  } cur_code_e;
endpackage

// File: rtl/cursor_geom_latch.sv
module cursor_geom_latch #(
  parameter int XW = 12,
  parameter int YW = 12,
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic [XW-1:0] reg_x,
  input  logic [YW-1:0] reg_y,
  input  logic [HW-1:0] reg_h,
  output logic [XW-1:0] eff_x,
  output logic [YW-1:0] eff_y,
  output logic [HW-1:0] eff_h
);
  logic [XW-1:0] sh_x;
  logic [YW-1:0] sh_y;
  logic [HW-1:0] sh_h;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_x <= '0;
      sh_y <= '0;
      sh_h <= '0;
    end else if (frame_start) begin
      sh_x <= reg_x;
      sh_y <= reg_y;
      sh_h <= reg_h;
    end
  end

  // The frame-start beat itself already sees the new geometry.
  always_comb begin
    eff_x = frame_start ? reg_x : sh_x;
    eff_y = frame_start ? reg_y : sh_y;
    eff_h = frame_start ? reg_h : sh_h;
  end

  // R7: the latched geometry moves only at a frame start
  a_r7_geom_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(sh_x) && $stable(sh_y) && $stable(sh_h)));
endmodule

// File: rtl/cursor_linebuf.sv
module cursor_linebuf #(
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [LINE_W-1:0] wdata,
  output logic [LINE_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (wr) q <= wdata;
  end

  // R10: contents change only on a write
  a_r10_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q));
endmodule

// File: rtl/cursor_window.sv
module cursor_window
  import cursor_pkg::*;
#(
  parameter int XW     = 12,
  parameter int YW     = 12,
  parameter int HW     = 12,
  parameter int CUR_W  = 32,
  parameter int CODE_W = 2,
  localparam int LINE_W = CUR_W * CODE_W,
  localparam int IDXW   = $clog2(CUR_W)
) (
  input  logic [XW-1:0]     beam_x,
  input  logic [YW-1:0]     beam_y,
  input  logic [XW-1:0]     win_x,
  input  logic [YW-1:0]     win_y,
  input  logic [HW-1:0]     win_h,
  input  logic [LINE_W-1:0] line,
  output logic              show,
  output cur_code_e         code
);
  logic [XW:0]     dx;
  logic [YW:0]     dy;
  logic            in_x, in_y;
  logic [IDXW-1:0] idx;
  logic [CODE_W-1:0] raw;

  always_comb begin
    dx   = {1'b0, beam_x} - {1'b0, win_x};
    dy   = {1'b0, beam_y} - {1'b0, win_y};
    in_x = !dx[XW] && (32'(dx[XW-1:0]) < 32'(CUR_W));
    in_y = !dy[YW] && (32'(dy[YW-1:0]) < 32'(win_h));
    idx  = dx[IDXW-1:0];
    raw  = line[idx*CODE_W +: CODE_W];
    code = cur_code_e'(raw);
    show = in_x && in_y && (code != CODE_CLEAR);
  end
endmodule

// File: rtl/cursor_colsel.sv
module cursor_colsel
  import cursor_pkg::*;
(
  input  logic      show,
  input  cur_code_e code,
  input  rgb_t      video,
  input  rgb_t      c1,
  input  rgb_t      c2,
  input  rgb_t      c3,
  output rgb_t      pix
);
  always_comb begin
    pix = video;
    if (show) begin
      unique case (code)
        CODE_C1: pix = c1;
        CODE_C2: pix = c2;
        CODE_C3: pix = c3;
        default: pix = video;
      endcase
    end
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int XW     = 12,
  parameter int YW     = 12,
  parameter int HW     = 12,
  parameter int CUR_W  = 32,
  parameter int CODE_W = 2,
  localparam int LINE_W = CUR_W * CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [XW-1:0]     in_x,
  input  logic [YW-1:0]     in_y,
  input  logic [RGB_W-1:0]  in_rgb,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [RGB_W-1:0]  out_rgb,
  input  logic [XW-1:0]     cur_x,
  input  logic [YW-1:0]     cur_y,
  input  logic [HW-1:0]     cur_h,
  input  logic [RGB_W-1:0]  col1,
  input  logic [RGB_W-1:0]  col2,
  input  logic [RGB_W-1:0]  col3,
  input  logic              line_wr,
  input  logic [LINE_W-1:0] line_data
);
  logic            accept, frame_start, show;
  logic [XW-1:0]   ex;
  logic [YW-1:0]   ey;
  logic [HW-1:0]   eh;
  logic [LINE_W-1:0] line_q;
  cur_code_e       code;
  rgb_t            pix;

  assign in_ready    = !out_valid || out_ready;
  assign accept      = in_valid && in_ready;
  assign frame_start = accept && (in_x == '0) && (in_y == '0);

  cursor_geom_latch #(.XW(XW), .YW(YW), .HW(HW)) u_geom (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .reg_x(cur_x), .reg_y(cur_y), .reg_h(cur_h),
    .eff_x(ex), .eff_y(ey), .eff_h(eh)
  );

  cursor_linebuf #(.LINE_W(LINE_W)) u_line (
    .clk(clk), .rst_n(rst_n), .wr(line_wr), .wdata(line_data), .q(line_q)
  );

  cursor_window #(.XW(XW), .YW(YW), .HW(HW), .CUR_W(CUR_W), .CODE_W(CODE_W)) u_win (
    .beam_x(in_x), .beam_y(in_y), .win_x(ex), .win_y(ey), .win_h(eh),
    .line(line_q), .show(show), .code(code)
  );

  cursor_colsel u_sel (
    .show(show), .code(code), .video(in_rgb),
    .c1(col1), .c2(col2), .c3(col3), .pix(pix)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_rgb <= pix;
    end
  end

  // R8: stalled output is held
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb)));

  // R8: an accepted beat shows up on the next cycle
  a_r8_accept_out: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R2 / R5 / R6: no cursor means the video colour passes
  a_r2_video_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !show) |=> (out_rgb == $past(in_rgb)));

  // R3: each non-zero code picks its own colour register
  a_r3_code_colour: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && show) |=>
      (out_rgb == (($past(code) == CODE_C1) ? $past(col1) :
                   ($past(code) == CODE_C2) ? $past(col2) : $past(col3))));
endmodule

// File: tb/tb_cursor_overlay.sv
module tb_cursor_overlay;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_x = '0, in_y = '0;
  logic [23:0] in_rgb = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_rgb;
  logic [11:0] cur_x = '0, cur_y = '0, cur_h = '0;
  logic [23:0] col1 = 24'h112233, col2 = 24'h445566, col3 = 24'h778899;
  logic        line_wr = 1'b0;
  logic [63:0] line_data = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  cursor_overlay dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_rgb(in_rgb), .out_valid(out_valid),
    .out_ready(out_ready), .out_rgb(out_rgb), .cur_x(cur_x), .cur_y(cur_y),
    .cur_h(cur_h), .col1(col1), .col2(col2), .col3(col3),
    .line_wr(line_wr), .line_data(line_data)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Send one beat with out_ready high; check the colour a cycle later.
  task automatic pix(input string tag, input logic [11:0] x, input logic [11:0] y,
                     input logic [23:0] rgb, input logic [23:0] exp);
    @(negedge clk);
    in_valid = 1'b1; in_x = x; in_y = y; in_rgb = rgb;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {23'd0, out_valid}, 24'd1);
    check(tag, out_rgb, exp);
  endtask

  // x, y, video, expected; window X=100 Y=50 H=4; line pattern codes i%4
  localparam int NV = 11;
  localparam logic [71:0] VEC [NV] = '{
    {12'd100, 12'd50, 24'hA0A001, 24'hA0A001}, // R2 R4 pixel 0 code 00
    {12'd101, 12'd50, 24'hA0A002, 24'h112233}, // R3 R4 code 01
    {12'd102, 12'd51, 24'hA0A003, 24'h445566}, // R3 code 10
    {12'd103, 12'd53, 24'hA0A004, 24'h778899}, // R3 R6 last row code 11
    {12'd131, 12'd50, 24'hA0A005, 24'h778899}, // R5 pixel 31
    {12'd132, 12'd50, 24'hA0A006, 24'hA0A006}, // R5 right of window
    {12'd99,  12'd50, 24'hA0A007, 24'hA0A007}, // R5 left of window
    {12'd101, 12'd54, 24'hA0A008, 24'hA0A008}, // R6 below window
    {12'd101, 12'd49, 24'hA0A009, 24'hA0A009}, // R6 above window
    {12'd104, 12'd52, 24'hA0A00A, 24'hA0A00A}, // R2 pixel 4 code 00
    {12'd129, 12'd52, 24'hA0A00B, 24'h112233}  // R4 pixel 29 code 01
  };

  initial begin
    logic [23:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", {23'd0, out_valid}, 24'd0);
    check("R1 in_ready", {23'd0, in_ready}, 24'd1);
    rst_n = 1'b1;
    // R1: zero height after reset, nothing drawn at origin
    pix("R1 no cursor", 12'd0, 12'd0, 24'h010203, 24'h010203);

    cur_x = 12'd100; cur_y = 12'd50; cur_h = 12'd4;
    @(negedge clk);
    line_data = 64'hE4E4_E4E4_E4E4_E4E4; line_wr = 1'b1; // R10
    @(negedge clk);
    line_wr = 1'b0;
    pix("R7 frame start", 12'd0, 12'd0, 24'h0A0B0C, 24'h0A0B0C);

    for (int i = 0; i < NV; i++)
      pix("table", VEC[i][71:60], VEC[i][59:48], VEC[i][47:24], VEC[i][23:0]);

    // R7: moving mid-frame has no effect until the next frame start
    cur_x = 12'd200;
    pix("R7 old position", 12'd101, 12'd50, 24'hB00001, 24'h112233);
    pix("R7 new frame", 12'd0, 12'd0, 24'hB00002, 24'hB00002);
    pix("R7 new position", 12'd201, 12'd50, 24'hB00003, 24'h112233);
    pix("R7 old spot clear", 12'd101, 12'd50, 24'hB00004, 24'hB00004);

    // R10: new line content takes effect; all pixels code 10
    @(negedge clk);
    line_data = 64'hAAAA_AAAA_AAAA_AAAA; line_wr = 1'b1;
    @(negedge clk);
    line_wr = 1'b0;
    pix("R10 new line", 12'd200, 12'd50, 24'hB00005, 24'h445566);

    // R6: zero height hides the cursor
    cur_h = 12'd0;
    pix("R6 zero height frame", 12'd0, 12'd0, 24'hC00001, 24'hC00001);
    pix("R6 zero height", 12'd201, 12'd50, 24'hC00002, 24'hC00002);
    cur_h = 12'd4;
    pix("R6 restore frame", 12'd0, 12'd0, 24'hC00003, 24'hC00003);

    // R8 R9 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_x = 12'd201; in_y = 12'd50; in_rgb = 24'hD00001;
    @(negedge clk);
    held = out_rgb;
    check("R8 first beat", out_rgb, 24'h445566);
    check("R9 stalled ready", {23'd0, in_ready}, 24'd0);
    in_x = 12'd10; in_rgb = 24'hD00002;
    repeat (2) @(negedge clk);
    check("R8 held colour", out_rgb, held);
    check("R8 held valid", {23'd0, out_valid}, 24'd1);
    out_ready = 1'b1;
    #1;
    check("R9 ready on drain", {23'd0, in_ready}, 24'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 second beat", out_rgb, 24'hD00002);
    @(negedge clk);
    check("R8 drained", {23'd0, out_valid}, 24'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule